// File: doc/BRIEF.md
# Dual GPIO Port Controller with Input Pullup Gating

This block is a register-mapped controller for two general-purpose I/O ports. Port A is seven pins wide. Each of its pins has an output latch, a direction bit and a pullup-enable bit. Port B is eight pins wide. Each of its pins has an output latch and a direction bit. Software reaches the registers through a small synchronous bus made of an address, write data, a write strobe and combinational read data. The pad ring receives per-pin output data, output enables and pullup requests, and it returns the raw pin levels.

A pullup request reaches a pad only while its enable bit is set and the pin is an input. It drops in the same cycle that the pin is switched to output. Pad levels pass through a two-flop synchronizer before they can be read. A data read returns the latch for output pins and the synchronized pad level for input pins. The output latches have no reset, so their contents survive a reset pulse. The direction and pullup-enable registers clear on reset.

Top module: `gpio_dual_port`

## Requirements
- R1: While reset is asserted and after it is released, every direction bit and every pullup-enable bit is 0. As a result all output enables and all pullup outputs are low.
- R2: A write to address 0x00 loads the port A latch and a write to 0x01 loads the port B latch. Each latch drives its port's output-data pins on the cycle after the write edge.
- R3: The direction registers are at 0x04 (port A) and 0x05 (port B). Bit n set to 1 makes pin n an output, and each output-enable pin equals its direction bit.
- R4: The port A pullup-enable register is at 0x0D, with bits 0 to 6 mapped to pins 0 to 6. A pullup output is 1 only when its enable bit is 1 and its direction bit is 0. It falls as soon as the direction register selects output.
- R5: Reading a data address returns, for each pin, the latch bit when that pin is an output and the synchronized pad level when it is an input. A pad change becomes readable after exactly two rising clock edges.
- R6: Writing a data register while its pins are inputs updates the latch, which is visible on the output-data pins, but does not change what the read returns for those pins.
- R7: Reset does not alter either port's data latch.
- R8: Bit 7 of every port A register reads as 0, and a write to that bit has no effect.
- R9: A write to any address other than 0x00, 0x01, 0x04, 0x05 and 0x0D changes no register, and a read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low asynchronous reset of direction, pullup and synchronizer state |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pa_in | input | 7 | Raw pad levels of port A |
| pa_out | output | 7 | Port A output data (latch contents) |
| pa_oe | output | 7 | Port A output enables |
| pa_pu | output | 7 | Port A effective pullup requests |
| pb_in | input | 8 | Raw pad levels of port B |
| pb_out | output | 8 | Port B output data (latch contents) |
| pb_oe | output | 8 | Port B output enables |

## Verification
The bench builds the block with its default parameters: a 7-pin port A, an 8-pin port B, two synchronizer stages and the addresses given above. Because port A is narrower than the 8-bit bus, the unimplemented top bit can be written and read back. Port B fills the whole bus, so mixed direction patterns cover both halves of the read mux. The two-stage depth lets the bench check the exact cycle in which a pad change becomes readable. Because reset leaves the latches alone, the bench can pulse reset between a latch write and its readback.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W      = 8;
  localparam int ADDR_W     = 8;
  localparam int PORT_MAX_W = 8;

  localparam int A_DATA_ADR = 'h00;
  localparam int B_DATA_ADR = 'h01;
  localparam int A_DIR_ADR  = 'h04;
  localparam int B_DIR_ADR  = 'h05;
  localparam int A_PUE_ADR  = 'h0D;

  typedef logic [PORT_MAX_W-1:0] pin_vec_t;

  // per pin: drive latch when output, sampled pad when input
  function automatic pin_vec_t pin_view(pin_vec_t latch, pin_vec_t pad, pin_vec_t dir);
    return (latch & dir) | (pad & ~dir);
  endfunction

  // pullup reaches the pad only on input pins
  function automatic pin_vec_t pullup_eff(pin_vec_t pue, pin_vec_t dir);
    return pue & ~dir;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          if (s == 0) stage_q[s] <= d_i;
          else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit HAS_PULLUP = 1'b0,
  parameter int DATA_ADR   = 0,
  parameter int DIR_ADR    = 4,
  parameter int PUE_ADR    = 13,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic              rd_hit_o,
  output logic [BUS_W-1:0]  rd_val_o,
  input  logic [WIDTH-1:0]  pad_i,
  output logic [WIDTH-1:0]  out_o,
  output logic [WIDTH-1:0]  oe_o,
  output logic [WIDTH-1:0]  pu_o
);
  localparam int PAD_W = PORT_MAX_W - WIDTH;

  logic [WIDTH-1:0] latch_q, dir_q, pue_q, pad_sync;
  logic             data_sel, dir_sel, pue_sel;
  logic             data_wr, dir_wr, pue_wr;
  pin_vec_t         view_full, pu_full;

  assign data_sel = (bus_addr == ADDR_W'(DATA_ADR));
  assign dir_sel  = (bus_addr == ADDR_W'(DIR_ADR));
  assign pue_sel  = HAS_PULLUP && (bus_addr == ADDR_W'(PUE_ADR));
  assign data_wr  = bus_we && data_sel;
  assign dir_wr   = bus_we && dir_sel;
  assign pue_wr   = bus_we && pue_sel;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pad_i), .q_o(pad_sync)
  );

  // output latch deliberately has no reset
  always_ff @(posedge clk) begin
    if (data_wr) latch_q <= bus_wdata[WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_wr) dir_q <= bus_wdata[WIDTH-1:0];
  end

  generate
    if (HAS_PULLUP) begin : g_pue
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pue_q <= '0;
        else if (pue_wr) pue_q <= bus_wdata[WIDTH-1:0];
      end
    end else begin : g_no_pue
      assign pue_q = '0;
    end
  endgenerate

  assign view_full = pin_view(PORT_MAX_W'(latch_q), PORT_MAX_W'(pad_sync), PORT_MAX_W'(dir_q));
  assign pu_full   = pullup_eff(PORT_MAX_W'(pue_q), PORT_MAX_W'(dir_q));

  always_comb begin
    rd_hit_o = 1'b0;
    rd_val_o = '0;
    if (data_sel) begin
      rd_hit_o = 1'b1;
      rd_val_o[WIDTH-1:0] = view_full[WIDTH-1:0];
    end else if (dir_sel) begin
      rd_hit_o = 1'b1;
      rd_val_o[WIDTH-1:0] = dir_q;
    end else if (pue_sel) begin
      rd_hit_o = 1'b1;
      rd_val_o[WIDTH-1:0] = pue_q;
    end
  end

  assign out_o = latch_q;
  assign oe_o  = dir_q;
  assign pu_o  = pu_full[WIDTH-1:0];

  // R1: direction clear on the first edge after reset
  a_r1_dir_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (dir_q == '0 && pue_q == '0));

  // R2: a data write lands in the latch
  a_r2_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (out_o == $past(bus_wdata[WIDTH-1:0])));

  // R4: no pin is pulled up while driven
  a_r4_pu_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_o & oe_o) == '0);

  // R9: writes elsewhere leave the direction and pullup state alone
  a_r9_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !data_sel && !dir_sel && !pue_sel) |=> ($stable(dir_q) && $stable(pue_q)));

  generate
    if (PAD_W > 0) begin : g_upper_chk
      // R8: bits above the port width read as zero
      a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_o |-> (rd_val_o[BUS_W-1:WIDTH] == '0));
    end
  endgenerate
endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port
  import gpio_pkg::*;
#(
  parameter int A_WIDTH  = 7,
  parameter int B_WIDTH  = 8,
  parameter int SYNC_STG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  input  logic               bus_we,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [A_WIDTH-1:0] pa_in,
  output logic [A_WIDTH-1:0] pa_out,
  output logic [A_WIDTH-1:0] pa_oe,
  output logic [A_WIDTH-1:0] pa_pu,
  input  logic [B_WIDTH-1:0] pb_in,
  output logic [B_WIDTH-1:0] pb_out,
  output logic [B_WIDTH-1:0] pb_oe
);
  logic             a_hit, b_hit;
  logic [BUS_W-1:0] a_val, b_val;
  logic [B_WIDTH-1:0] b_pu_unused;

  gpio_port #(
    .WIDTH(A_WIDTH), .HAS_PULLUP(1'b1), .DATA_ADR(A_DATA_ADR),
    .DIR_ADR(A_DIR_ADR), .PUE_ADR(A_PUE_ADR), .SYNC_STG(SYNC_STG)
  ) u_port_a (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .rd_hit_o(a_hit), .rd_val_o(a_val), .pad_i(pa_in),
    .out_o(pa_out), .oe_o(pa_oe), .pu_o(pa_pu)
  );

  gpio_port #(
    .WIDTH(B_WIDTH), .HAS_PULLUP(1'b0), .DATA_ADR(B_DATA_ADR),
    .DIR_ADR(B_DIR_ADR), .PUE_ADR(A_PUE_ADR), .SYNC_STG(SYNC_STG)
  ) u_port_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .rd_hit_o(b_hit), .rd_val_o(b_val), .pad_i(pb_in),
    .out_o(pb_out), .oe_o(pb_oe), .pu_o(b_pu_unused)
  );

  assign bus_rdata = (a_hit ? a_val : '0) | (b_hit ? b_val : '0);

  // R9: unmapped reads return zero
  a_r9_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_hit && !b_hit) |-> (bus_rdata == '0));

  // R3: output enables follow the direction registers across a write
  a_r3_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(B_DIR_ADR)) |=> (pb_oe == $past(bus_wdata[B_WIDTH-1:0])));
endmodule

// File: tb/gpio_dual_port_tb_top.sv
module gpio_dual_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  // {write, addr, data, expected read}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 8'h7F, 8'h00},  // R2 load port A latch
    {1'b1, 8'h01, 8'hC3, 8'h00},  // R2 load port B latch
    {1'b0, 8'h04, 8'h00, 8'h00},  // R3 dir A still zero
    {1'b0, 8'h00, 8'h00, 8'h2A},  // R5 all inputs -> pads
    {1'b0, 8'h01, 8'h00, 8'h3C},  // R5
    {1'b1, 8'h04, 8'h0F, 8'h00},  // R3
    {1'b0, 8'h00, 8'h00, 8'h2F},  // R5 mixed A
    {1'b1, 8'h05, 8'hF0, 8'h00},  // R3
    {1'b0, 8'h01, 8'h00, 8'hCC},  // R5 mixed B
    {1'b0, 8'h05, 8'h00, 8'hF0},  // R3 readback
    {1'b1, 8'h0D, 8'hFF, 8'h00},  // R4
    {1'b0, 8'h0D, 8'h00, 8'h7F},  // R8 bit7 of pullup reg
    {1'b0, 8'h04, 8'h00, 8'h0F},  // R3
    {1'b0, 8'h02, 8'h00, 8'h00},  // R9 unmapped read
    {1'b1, 8'h02, 8'hFF, 8'h00},  // R9 unmapped write
    {1'b0, 8'h0D, 8'h00, 8'h7F},  // R9 pullup unchanged
    {1'b1, 8'h04, 8'hFF, 8'h00},  // R8 write bit7 of dir
    {1'b0, 8'h04, 8'h00, 8'h7F}   // R8
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_we;
  logic [6:0] pa_in, pa_out, pa_oe, pa_pu;
  logic [7:0] pb_in, pb_out, pb_oe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_dual_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .pa_pu(pa_pu), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
    pa_in = 7'h2A; pb_in = 8'h3C;
    repeat (3) @(negedge clk);
    check("R1 pa_oe in reset", {1'b0, pa_oe}, 8'h00);
    check("R1 pb_oe in reset", pb_oe, 8'h00);
    check("R1 pa_pu in reset", {1'b0, pa_pu}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd("R1 dir A", 8'h04, 8'h00);
    rd("R1 dir B", 8'h05, 8'h00);
    rd("R1 pue A", 8'h0D, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][24]) wr(VEC[i][23:16], VEC[i][15:8]);
      else begin
        @(negedge clk);
        rd($sformatf("R-vec%0d", i), VEC[i][23:16], VEC[i][7:0]);
      end
    end
    check("R2 pa_out", {1'b0, pa_out}, 8'h7F);
    check("R2 pb_out", pb_out, 8'hC3);
    check("R3 pb_oe", pb_oe, 8'hF0);
    rd("R2 A all outputs", 8'h00, 8'h7F);

    // R4 gating follows direction at once
    wr(8'h04, 8'h0F);
    check("R4 pu with dir 0F", {1'b0, pa_pu}, 8'h70);
    check("R3 pa_oe", {1'b0, pa_oe}, 8'h0F);
    wr(8'h04, 8'h3F);
    check("R4 pu after dir 3F", {1'b0, pa_pu}, 8'h40);
    wr(8'h0D, 8'h00);
    check("R4 pu disabled", {1'b0, pa_pu}, 8'h00);

    // R5 two-edge synchronizer latency on port B low nibble
    @(negedge clk);
    pb_in = 8'h35;
    @(negedge clk);
    rd("R5 one edge old", 8'h01, 8'hCC);
    @(negedge clk);
    rd("R5 two edges new", 8'h01, 8'hC5);

    // R6 write while input
    wr(8'h01, 8'h0F);
    rd("R6 input read unchanged", 8'h01, 8'h05);
    check("R6 latch visible", pb_out, 8'h0F);

    // R7 latches survive reset
    wr(8'h01, 8'h5A);
    wr(8'h00, 8'h33);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 pb latch", pb_out, 8'h5A);
    check("R7 pa latch", {1'b0, pa_out}, 8'h33);
    check("R1 pb_oe after reset", pb_oe, 8'h00);
    wr(8'h05, 8'hFF);
    rd("R7 pb readback", 8'h01, 8'h5A);

    // R9 unmapped write and read
    wr(8'h10, 8'hAA);
    rd("R9 pb data kept", 8'h01, 8'h5A);
    rd("R9 read 10", 8'h10, 8'h00);
    rd("R9 read 0E", 8'h0E, 8'h00);
    rd("R9 dir B kept", 8'h05, 8'hFF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule